// File: doc/BRIEF.md
# DMA Burst Length Counter Engine

This block does the byte counting for a bus-master DMA channel that sits next to a SCSI protocol core. Software starts a transfer by programming a byte count, a start address and a direction, then pulses the start command. The start command copies the count and the address into working counters and enables the channel. From then on the SCSI core issues transfer requests. Each request carries a requested length and the direction the core wants to move data in.

For every accepted request the engine first compares the requested direction with the direction latched at start. A request in the wrong direction is discarded. Otherwise the engine clamps the requested length to the bytes that remain and issues one memory request. That request carries the start-address register value, the clamped length and a write flag. The memory side is modelled as a simple request/acknowledge pair. When the acknowledge arrives, the working count goes down by the burst length and the working address goes up by the same amount. A sticky done flag is raised once the working count is zero.

Top module: `dma_burst_counter`

## Requirements
- R1: After reset the working count is 0, the working address is all ones, done is 0, req_ready is 0 and mem_req is 0.
- R2: A cmd_start pulse loads work_count from start_count and work_addr from start_addr, and clears xfer_done. It also latches cfg_to_mem as the channel direction and enables the channel, so req_ready is 1 on the next cycle when no burst is in flight.
- R3: After a cmd_stop pulse req_ready is 0. Requests presented while stopped are not accepted: no response, no memory request and no counter change.
- R4: The expected direction is memory write (req_to_mem = 1) when the latched direction bit is 1, and memory read (req_to_mem = 0) when it is 0. Changing cfg_to_mem after start has no effect until the next start.
- R5: An accepted request whose direction differs from the expected one is dropped. One cycle after acceptance rsp_valid = 1, rsp_drop = 1 and rsp_len = 0. mem_req stays 0, and work_count, work_addr and xfer_done are unchanged.
- R6: The burst length on mem_len is the smaller of req_len and work_count. It is never zero while mem_req is 1.
- R7: mem_addr carries the value of start_addr in the accept cycle, whatever the working address is. mem_write carries the latched direction bit.
- R8: mem_req goes high the cycle after acceptance. It then holds with stable mem_addr and mem_len until mem_ack is seen, and the counters do not move while it waits.
- R9: In the cycle mem_ack is seen with mem_req high, work_count drops by mem_len and work_addr rises by mem_len (modulo 2^ADDR_W). One cycle later rsp_valid = 1, rsp_drop = 0, rsp_len = mem_len, and mem_req is 0.
- R10: xfer_done is set when a burst or zero-length response leaves work_count at zero. It stays set until the next cmd_start.
- R11: An accepted request in the right direction whose clamped length is zero issues no memory request. It is answered one cycle later with rsp_valid = 1, rsp_drop = 0 and rsp_len = 0, and the counters are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse: load counters, latch direction, enable |
| cmd_stop | input | 1 | Stop pulse: disable request acceptance |
| cfg_to_mem | input | 1 | Direction bit, 1 = device to memory, sampled at start |
| start_count | input | CNT_W | Programmed byte count |
| start_addr | input | ADDR_W | Programmed start address register |
| req_valid | input | 1 | Transfer request from the SCSI core |
| req_ready | output | 1 | Engine can accept a request |
| req_len | input | CNT_W | Requested length in bytes |
| req_to_mem | input | 1 | Requested direction, 1 = device to memory |
| rsp_valid | output | 1 | One-cycle completion of an accepted request |
| rsp_drop | output | 1 | Request was discarded for wrong direction |
| rsp_len | output | CNT_W | Bytes moved by the request |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory request address |
| mem_len | output | CNT_W | Memory request length |
| mem_ack | input | 1 | Memory acknowledge |
| work_count | output | CNT_W | Working byte count |
| work_addr | output | ADDR_W | Working address |
| xfer_done | output | 1 | Sticky done status |

## Verification
The assertions take three things for granted about the inputs. mem_ack is only raised while mem_req is high. cmd_start and cmd_stop are never raised in the same cycle. cmd_start is never raised while a burst waits for its acknowledge. The stimulus keeps to these rules because every input is driven from a few bench tasks. A new start is issued only between requests. The acknowledge is raised only after mem_req has been seen high. Each request task runs one request to its response before it returns.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_MEM  = 1'b1
  } eng_state_t;
endpackage

// File: rtl/dma_accept_decode.sv
module dma_accept_decode #(
  parameter int CNT_W = 16
) (
  input  logic             accept,
  input  logic             dir_latched,
  input  logic             req_to_mem,
  input  logic [CNT_W-1:0] req_len,
  input  logic [CNT_W-1:0] wcount,
  output logic [CNT_W-1:0] clamp_len,
  output logic             go_drop,
  output logic             go_zero,
  output logic             go_mem
);
  function automatic logic [CNT_W-1:0] smaller(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic dir_ok;

  assign dir_ok    = (req_to_mem == dir_latched);
  assign clamp_len = smaller(req_len, wcount);
  assign go_drop   = accept && !dir_ok;
  assign go_zero   = accept && dir_ok && (clamp_len == '0);
  assign go_mem    = accept && dir_ok && (clamp_len != '0);
endmodule

// File: rtl/dma_work_regs.sv
module dma_work_regs #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic [CNT_W-1:0]  step_len,
  input  logic              zero_end,
  output logic [CNT_W-1:0]  wcount,
  output logic [ADDR_W-1:0] waddr,
  output logic              done
);
  function automatic logic [CNT_W-1:0] cnt_after(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] l);
    return c - l;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_after(input logic [ADDR_W-1:0] a,
                                                   input logic [CNT_W-1:0]  l);
    return a + ADDR_W'(l);
  endfunction

  logic [CNT_W-1:0] next_cnt;
  assign next_cnt = cnt_after(wcount, step_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcount <= '0;
      waddr  <= '1;
      done   <= 1'b0;
    end else if (load) begin
      wcount <= load_cnt;
      waddr  <= load_addr;
      done   <= 1'b0;
    end else if (step) begin
      wcount <= next_cnt;
      waddr  <= addr_after(waddr, step_len);
      if (next_cnt == '0) done <= 1'b1;
    end else if (zero_end) begin
      if (wcount == '0) done <= 1'b1;
    end
  end

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> done);
  // R10
  done_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && (step_len == wcount) |=> done);
  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> wcount == $past(wcount) - $past(step_len));
  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> waddr == $past(waddr) + ADDR_W'($past(step_len)));
  // R8
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step |=> $stable(wcount) && $stable(waddr));
endmodule

// File: rtl/dma_burst_counter.sv
module dma_burst_counter
  import dma_cnt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              cfg_to_mem,
  input  logic [CNT_W-1:0]  start_count,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CNT_W-1:0]  req_len,
  input  logic              req_to_mem,
  output logic              rsp_valid,
  output logic              rsp_drop,
  output logic [CNT_W-1:0]  rsp_len,
  output logic              mem_req,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  mem_len,
  input  logic              mem_ack,
  output logic [CNT_W-1:0]  work_count,
  output logic [ADDR_W-1:0] work_addr,
  output logic              xfer_done
);
  eng_state_t       state;
  logic             enabled;
  logic             dir_q;
  logic             accept;
  logic             go_drop, go_zero, go_mem;
  logic             mem_done;
  logic [CNT_W-1:0] clamp_len;

  assign req_ready = enabled && (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_done  = (state == ST_MEM) && mem_ack;
  assign mem_req   = (state == ST_MEM);
  assign mem_write = dir_q;

  dma_accept_decode #(.CNT_W(CNT_W)) u_dec (
    .accept      (accept),
    .dir_latched (dir_q),
    .req_to_mem  (req_to_mem),
    .req_len     (req_len),
    .wcount      (work_count),
    .clamp_len   (clamp_len),
    .go_drop     (go_drop),
    .go_zero     (go_zero),
    .go_mem      (go_mem)
  );

  dma_work_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_start),
    .load_cnt  (start_count),
    .load_addr (start_addr),
    .step      (mem_done),
    .step_len  (mem_len),
    .zero_end  (go_zero),
    .wcount    (work_count),
    .waddr     (work_addr),
    .done      (xfer_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      dir_q   <= 1'b0;
    end else if (cmd_start) begin
      enabled <= 1'b1;
      dir_q   <= cfg_to_mem;
    end else if (cmd_stop) begin
      enabled <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mem_addr <= '0;
      mem_len  <= '0;
    end else if (go_mem) begin
      state    <= ST_MEM;
      mem_addr <= start_addr;
      mem_len  <= clamp_len;
    end else if (mem_done) begin
      state    <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_drop  <= 1'b0;
      rsp_len   <= '0;
    end else begin
      rsp_valid <= go_drop || go_zero || mem_done;
      rsp_drop  <= go_drop;
      rsp_len   <= mem_done ? mem_len : '0;
    end
  end

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_len));
  // R6
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0) && (mem_len <= work_count));
  // R5
  drop_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_drop |-> (rsp_len == '0) && !mem_req);
  // R5
  drop_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_drop |=> !mem_req && $stable(work_count) && $stable(xfer_done));
  // R3
  stop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop && !cmd_start |=> !req_ready);
  // R11
  zero_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_zero |=> !mem_req && rsp_valid && (rsp_len == '0));
  // R9
  ack_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> rsp_valid && !rsp_drop && (rsp_len == $past(mem_len)) && !mem_req);
endmodule

// File: tb/sim_dma_burst_counter.sv
module sim_dma_burst_counter;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_start = 1'b0, cmd_stop = 1'b0, cfg_to_mem = 1'b0;
  logic [CNT_W-1:0]  start_count = '0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              req_valid = 1'b0, req_to_mem = 1'b0, mem_ack = 1'b0;
  logic [CNT_W-1:0]  req_len = '0;
  logic              req_ready, rsp_valid, rsp_drop, mem_req, mem_write, xfer_done;
  logic [CNT_W-1:0]  rsp_len, mem_len, work_count;
  logic [ADDR_W-1:0] mem_addr, work_addr;

  int total = 0;
  int bad   = 0;

  logic [CNT_W-1:0]  e_cnt;
  logic [ADDR_W-1:0] e_addr;
  logic              e_done, e_dir;

  always #2 clk = ~clk;

  dma_burst_counter #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cfg_to_mem(cfg_to_mem), .start_count(start_count), .start_addr(start_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
    .req_to_mem(req_to_mem), .rsp_valid(rsp_valid), .rsp_drop(rsp_drop),
    .rsp_len(rsp_len), .mem_req(mem_req), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_ack(mem_ack),
    .work_count(work_count), .work_addr(work_addr), .xfer_done(xfer_done)
  );

  function automatic logic [CNT_W-1:0] bench_clamp(input logic [CNT_W-1:0] want,
                                                   input logic [CNT_W-1:0] left);
    if (want > left) return left;
    return want;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_counters(input string req);
    chk(work_count == e_cnt, req, work_count, e_cnt);
    chk(work_addr == e_addr, req, work_addr, e_addr);
    chk(xfer_done == e_done, req, xfer_done, e_done);
  endtask

  task automatic do_start(input logic [CNT_W-1:0] cnt, input logic [ADDR_W-1:0] adr,
                          input bit dir);
    @(negedge clk);
    start_count = cnt; start_addr = adr; cfg_to_mem = dir; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    e_cnt = cnt; e_addr = adr; e_done = 1'b0; e_dir = dir;
    chk_counters("R2");
    chk(req_ready == 1'b1, "R2", req_ready, 1);
  endtask

  task automatic do_req(input logic [CNT_W-1:0] len, input bit to_mem, input int dly);
    logic [CNT_W-1:0]  cl;
    logic [ADDR_W-1:0] sa;
    int guard;
    guard = 0;
    while (!req_ready && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    chk(req_ready == 1'b1, "R2", req_ready, 1);
    cl = bench_clamp(len, e_cnt);
    sa = start_addr;
    req_valid = 1'b1; req_len = len; req_to_mem = to_mem;
    @(negedge clk);
    req_valid = 1'b0;
    if (to_mem != e_dir) begin
      // R4 R5: wrong direction is discarded
      chk(rsp_valid && rsp_drop && rsp_len == '0, "R5", {rsp_valid, rsp_drop, rsp_len}, 3 << CNT_W);
      chk(mem_req == 1'b0, "R5", mem_req, 0);
      chk_counters("R5");
    end else if (cl == '0) begin
      // R11: zero-length burst
      if (e_cnt == '0) e_done = 1'b1;
      chk(rsp_valid && !rsp_drop && rsp_len == '0, "R11", {rsp_valid, rsp_drop, rsp_len}, 2 << CNT_W);
      chk(mem_req == 1'b0, "R11", mem_req, 0);
      chk_counters("R11");
    end else begin
      chk(mem_req == 1'b1, "R8", mem_req, 1);
      chk(mem_len == cl, "R6", mem_len, cl);
      chk(mem_addr == sa, "R7", mem_addr, sa);
      chk(mem_write == e_dir, "R4", mem_write, e_dir);
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        chk(mem_req && mem_len == cl && mem_addr == sa, "R8", mem_len, cl);
        chk(work_count == e_cnt && !rsp_valid, "R8", work_count, e_cnt);
      end
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
      e_cnt  = e_cnt - cl;
      e_addr = e_addr + ADDR_W'(cl);
      if (e_cnt == '0) e_done = 1'b1;
      chk(rsp_valid && !rsp_drop && rsp_len == cl, "R9", rsp_len, cl);
      chk(mem_req == 1'b0, "R9", mem_req, 0);
      chk(work_count == e_cnt, "R9", work_count, e_cnt);
      chk(work_addr == e_addr, "R9", work_addr, e_addr);
      chk(xfer_done == e_done, "R10", xfer_done, e_done);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(work_count == '0, "R1", work_count, 0);
    chk(work_addr == '1, "R1", work_addr, 32'hFFFF_FFFF);
    chk(!xfer_done && !req_ready && !mem_req, "R1", {xfer_done, req_ready, mem_req}, 0);

    do_start(16'd100, 32'h0000_1000, 1'b1);
    do_req(16'd40, 1'b1, 2);
    do_req(16'd5, 1'b0, 0);
    // R4: direction input changed after start is ignored
    cfg_to_mem = 1'b0;
    // R7: start address register rewritten; the burst uses it, not work_addr
    start_addr = 32'h0000_2000;
    do_req(16'd100, 1'b1, 0);
    do_req(16'd10, 1'b1, 1);

    // R3: stopped channel accepts nothing
    @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    chk(req_ready == 1'b0, "R3", req_ready, 0);
    req_valid = 1'b1; req_len = 16'd4; req_to_mem = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!rsp_valid && !mem_req, "R3", {rsp_valid, mem_req}, 0);
    end
    req_valid = 1'b0;
    chk_counters("R3");

    // R11: zero request with bytes left keeps done low
    do_start(16'd50, 32'hFFFF_FFF0, 1'b0);
    do_req(16'd0, 1'b0, 0);
    // R9: address wraps past all ones
    do_req(16'd20, 1'b0, 3);
    // R10: done after exact drain, sticky across a later zero burst
    do_req(16'd30, 1'b0, 0);
    do_req(16'd7, 1'b0, 0);
    do_req(16'd7, 1'b1, 0);

    for (int n = 0; n < 300; n++) begin
      if (e_done || ($urandom % 20) == 0)
        do_start(16'($urandom % 300 + 1), $urandom, 1'($urandom % 2));
      cfg_to_mem = 1'($urandom % 2);
      if (($urandom % 8) == 0) start_addr = $urandom;
      do_req(16'($urandom % 80), (($urandom % 6) == 0) ? !e_dir : e_dir, int'($urandom % 4));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule